// File: doc/BRIEF.md
# Data-Processing Result and Flag Unit

This block is the result and flag stage of a 32-bit processor's data-processing datapath. It receives a 4-bit operation code, the first operand, a second operand that has already passed through the barrel shifter, the shifter's carry-out, and the current N, Z, C and V condition flags. It produces the value to be written to the destination register, the next value of the four flags, and a strobe asking the status register to reload itself from its saved copy. It is purely combinational, so everything settles within the cycle in which the inputs are presented.

Five operations are supported: move, move-inverted, bitwise OR, reverse subtract (second operand minus first operand) and reverse subtract with carry. The subtractions report carry as NOT-borrow, which lets two of them be chained to negate a value wider than one word. The block also recognises an encoding that looks like a register-form data-processing instruction but is really a different instruction class, and signals that it is not one of its own.

The unit has no state machine and no registers. Its internal structure is a decoder that classifies the operation, a logic path, a subtract path, and a flag merge in the top module that picks between them.

Top module: `dp_result_unit`

## Requirements
- R1: Operation code 4'b1101 selects move: result equals the second operand.
- R2: Operation code 4'b1111 selects move-inverted (result is the bitwise complement of the second operand); 4'b1100 selects OR (result is first operand OR second operand).
- R3: Operation code 4'b0011 selects reverse subtract: result is second operand minus first operand, modulo 2^32.
- R4: Operation code 4'b0111 selects reverse subtract with carry: result is second operand minus first operand minus NOT(C), where C is flags_i bit 1.
- R5: When a subtraction updates the flags, N is result bit 31, Z is 1 exactly when the result is zero, C is 1 when no borrow occurs and 0 when one does, and V is the signed overflow of the subtraction. Flag vector layout is N at bit 3, Z at bit 2, C at bit 1, V at bit 0.
- R6: When move, move-inverted or OR updates the flags, N and Z come from the result, C is the shifter carry-out, and V keeps its input value.
- R7: With set-flags low, flags_o equals flags_i for every operation while the result is still produced.
- R8: With set-flags high and the destination being register 15, flags_o equals flags_i and the restore strobe is 1; the result is still produced. In every other case the restore strobe is 0.
- R9: When the immediate-form bit is 0 and encoding bits 7 and 4 are both 1, not_dp_o is 1, the result is zero, flags_o equals flags_i and the restore strobe is 0. When the immediate-form bit is 1, bits 7 and 4 have no effect.
- R10: Any operation code other than the five above gives a zero result, flags_o equal to flags_i and no restore strobe.
- R11: A 64-bit value is negated by a flag-setting reverse subtract of the low word from zero followed by a reverse subtract with carry of the high word from zero, feeding the first flags output into the second flags input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 4 | Operation code (instruction bits 24..21) |
| imm_form_i | input | 1 | Immediate-form bit (instruction bit 25) |
| enc_b7_i | input | 1 | Instruction bit 7 |
| enc_b4_i | input | 1 | Instruction bit 4 |
| rn_i | input | 32 | First operand |
| opnd2_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Barrel shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| set_flags_i | input | 1 | Flag-setting form of the instruction |
| dest_pc_i | input | 1 | Destination is register 15 |
| result_o | output | 32 | Value for the destination register |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| restore_status_o | output | 1 | Reload status register from its saved copy |
| not_dp_o | output | 1 | Encoding belongs to another instruction class |

## Verification
There is no stored state, so a wrong internal classification or carry shows at the ports in the same cycle the inputs are applied: a mis-decoded operation gives a wrong result word, an inverted borrow sense gives a wrong C bit and breaks the 64-bit negation on its high word, and a leaked flag update in the restore or non-data-processing cases shows as flags_o differing from flags_i. The bench therefore applies each input pattern, lets it settle, and compares every output against values worked out from wide integer arithmetic rather than from the unit's own adder structure.

// File: rtl/dpru_pkg.sv
package dpru_pkg;

    localparam int OPC_W = 4;
    localparam int FLG_W = 4;

    // Flag vector bit positions
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    // Operation codes (instruction bits 24..21)
    localparam logic [OPC_W-1:0] OPC_MOVE  = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_MOVN  = 4'b1111;
    localparam logic [OPC_W-1:0] OPC_OR    = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_RSUB  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_RSUBC = 4'b0111;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_MOVE  = 3'd1,
        K_MOVN  = 3'd2,
        K_OR    = 3'd3,
        K_RSUB  = 3'd4,
        K_RSUBC = 3'd5
    } op_kind_e;

    function automatic logic kind_is_sub(input op_kind_e k);
        return (k == K_RSUB) || (k == K_RSUBC);
    endfunction

    function automatic logic kind_is_logic(input op_kind_e k);
        return (k == K_MOVE) || (k == K_MOVN) || (k == K_OR);
    endfunction

endpackage

// File: rtl/dpru_decode.sv
module dpru_decode
    import dpru_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic             imm_form_i,
    input  logic             enc_b7_i,
    input  logic             enc_b4_i,
    output op_kind_e         kind_o,
    output logic             not_dp_o
);

    logic foreign_enc;

    always_comb begin
        foreign_enc = !imm_form_i && enc_b7_i && enc_b4_i;
        not_dp_o    = foreign_enc;
        kind_o      = K_NONE;
        if (!foreign_enc) begin
            case (opc_i)
                OPC_MOVE:  kind_o = K_MOVE;
                OPC_MOVN:  kind_o = K_MOVN;
                OPC_OR:    kind_o = K_OR;
                OPC_RSUB:  kind_o = K_RSUB;
                OPC_RSUBC: kind_o = K_RSUBC;
                default:   kind_o = K_NONE;
            endcase
        end
    end

    always_comb begin
        if (!$isunknown({opc_i, imm_form_i, enc_b7_i, enc_b4_i})) begin
            AST_FOREIGN_HAS_NO_KIND: assert (!not_dp_o || kind_o == K_NONE); // R9
            AST_IMM_FORM_NEVER_FOREIGN: assert (!imm_form_i || !not_dp_o); // R9
        end
    end

endmodule

// File: rtl/dpru_logic.sv
module dpru_logic
    import dpru_pkg::*;
#(
    parameter int W = 32
) (
    input  op_kind_e       kind_i,
    input  logic [W-1:0]   rn_i,
    input  logic [W-1:0]   opnd2_i,
    output logic [W-1:0]   result_o
);

    always_comb begin
        unique case (kind_i)
            K_MOVE:  result_o = opnd2_i;
            K_MOVN:  result_o = ~opnd2_i;
            K_OR:    result_o = rn_i | opnd2_i;
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/dpru_subtract.sv
module dpru_subtract #(
    parameter int W = 32
) (
    input  logic [W-1:0] minuend_i,
    input  logic [W-1:0] subtrahend_i,
    input  logic         no_borrow_in_i,
    output logic [W-1:0] diff_o,
    output logic         no_borrow_out_o,
    output logic         ovf_o
);

    localparam int EW = W + 1;

    logic [EW-1:0] sum_ext;

    // minuend + ~subtrahend + carry-in == minuend - subtrahend - !carry-in
    always_comb begin
        sum_ext         = {1'b0, minuend_i} + {1'b0, ~subtrahend_i}
                          + {{(EW-1){1'b0}}, no_borrow_in_i};
        diff_o          = sum_ext[W-1:0];
        no_borrow_out_o = sum_ext[W];
        ovf_o           = (minuend_i[W-1] != subtrahend_i[W-1])
                          && (diff_o[W-1] != minuend_i[W-1]);
    end

    logic [EW:0] need_ext;
    always_comb begin
        need_ext = {2'b00, subtrahend_i} + {{EW{1'b0}}, !no_borrow_in_i};
        if (!$isunknown({minuend_i, subtrahend_i, no_borrow_in_i})) begin
            AST_CARRY_IS_NOT_BORROW: assert (no_borrow_out_o ==
                ({2'b00, minuend_i} >= need_ext)); // R5
        end
    end

endmodule

// File: rtl/dp_result_unit.sv
module dp_result_unit
    import dpru_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] opc_i,
    input  logic             imm_form_i,
    input  logic             enc_b7_i,
    input  logic             enc_b4_i,
    input  logic [W-1:0]     rn_i,
    input  logic [W-1:0]     opnd2_i,
    input  logic             shift_carry_i,
    input  logic [FLG_W-1:0] flags_i,
    input  logic             set_flags_i,
    input  logic             dest_pc_i,
    output logic [W-1:0]     result_o,
    output logic [FLG_W-1:0] flags_o,
    output logic             restore_status_o,
    output logic             not_dp_o
);

    op_kind_e     kind;
    logic [W-1:0] logic_res;
    logic [W-1:0] sub_res;
    logic         sub_c;
    logic         sub_v;
    logic         sub_cin;
    logic         is_sub;
    logic         is_logic;
    logic         writes_flags;

    dpru_decode u_decode (
        .opc_i      (opc_i),
        .imm_form_i (imm_form_i),
        .enc_b7_i   (enc_b7_i),
        .enc_b4_i   (enc_b4_i),
        .kind_o     (kind),
        .not_dp_o   (not_dp_o)
    );

    dpru_logic #(.W(W)) u_logic (
        .kind_i   (kind),
        .rn_i     (rn_i),
        .opnd2_i  (opnd2_i),
        .result_o (logic_res)
    );

    assign sub_cin = (kind == K_RSUBC) ? flags_i[FLG_C] : 1'b1;

    dpru_subtract #(.W(W)) u_subtract (
        .minuend_i       (opnd2_i),
        .subtrahend_i    (rn_i),
        .no_borrow_in_i  (sub_cin),
        .diff_o          (sub_res),
        .no_borrow_out_o (sub_c),
        .ovf_o           (sub_v)
    );

    always_comb begin
        is_sub           = kind_is_sub(kind);
        is_logic         = kind_is_logic(kind);
        result_o         = is_sub ? sub_res : logic_res;
        writes_flags     = set_flags_i && !dest_pc_i && (is_sub || is_logic);
        restore_status_o = set_flags_i && dest_pc_i && (is_sub || is_logic);
        flags_o          = flags_i;
        if (writes_flags) begin
            flags_o[FLG_N] = result_o[W-1];
            flags_o[FLG_Z] = (result_o == '0);
            flags_o[FLG_C] = is_sub ? sub_c : shift_carry_i;
            flags_o[FLG_V] = is_sub ? sub_v : flags_i[FLG_V];
        end
    end

    always_comb begin
        if (!$isunknown({opc_i, imm_form_i, enc_b7_i, enc_b4_i, rn_i, opnd2_i,
                         shift_carry_i, flags_i, set_flags_i, dest_pc_i})) begin
            AST_RESTORE_KEEPS_FLAGS: assert (!restore_status_o || flags_o == flags_i); // R8
            AST_RESTORE_NEEDS_PC: assert (!restore_status_o || (set_flags_i && dest_pc_i)); // R8
            AST_FOREIGN_IS_QUIET: assert (!not_dp_o || (!restore_status_o
                && result_o == '0 && flags_o == flags_i)); // R9
            AST_NO_SET_NO_CHANGE: assert (set_flags_i || flags_o == flags_i); // R7
            AST_LOGIC_KEEPS_V: assert (!is_logic || flags_o[FLG_V] == flags_i[FLG_V]); // R6
            AST_ZERO_MATCHES_RESULT: assert (!writes_flags
                || flags_o[FLG_Z] == (result_o == '0)); // R5
        end
    end

endmodule

// File: tb/tb_dp_result_unit.sv
module tb_dp_result_unit;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]  opc;
    logic        imm, b7, b4;
    logic [31:0] rn, op2;
    logic        shc;
    logic [3:0]  fin;
    logic        sf, pc;
    logic [31:0] res;
    logic [3:0]  fout;
    logic        rst_o, ndp;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    dp_result_unit dut (
        .opc_i            (opc),
        .imm_form_i       (imm),
        .enc_b7_i         (b7),
        .enc_b4_i         (b4),
        .rn_i             (rn),
        .opnd2_i          (op2),
        .shift_carry_i    (shc),
        .flags_i          (fin),
        .set_flags_i      (sf),
        .dest_pc_i        (pc),
        .result_o         (res),
        .flags_o          (fout),
        .restore_status_o (rst_o),
        .not_dp_o         (ndp)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic im, input logic x7,
                         input logic x4, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [3:0] f, input logic s,
                         input logic p);
        @(negedge clk);
        opc = o; imm = im; b7 = x7; b4 = x4; rn = a; op2 = b;
        shc = sc; fin = f; sf = s; pc = p;
        #2;
    endtask

    // Expected {flags, result} of op2 - rn - !c from wide integer arithmetic
    function automatic logic [35:0] model_sub(input logic [31:0] b,
                                              input logic [31:0] a, input logic c);
        longint u, s;
        logic [31:0] r;
        logic n, z, cc, v;
        u  = longint'({32'd0, b}) - longint'({32'd0, a}) - (c ? 0 : 1);
        s  = longint'($signed(b)) - longint'($signed(a)) - (c ? 0 : 1);
        r  = u[31:0];
        n  = r[31];
        z  = (r == 0);
        cc = (u >= 0);
        v  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {n, z, cc, v, r};
    endfunction

    task automatic t_idle;
        apply(4'b0000, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 4'b0000, 1'b0, 1'b0);
        chk("R10", "idle result", res, 32'd0);
        chk("R10", "idle flags", {28'd0, fout}, 32'd0);
        chk("R8", "idle restore", {31'd0, rst_o}, 32'd0);
        chk("R9", "idle not_dp", {31'd0, ndp}, 32'd0);
    endtask

    task automatic t_move;
        apply(4'b1101, 1'b1, 1'b0, 1'b0, 32'h1234, 32'h8000_0000, 1'b1, 4'b0001, 1'b1, 1'b0);
        chk("R1", "move result", res, 32'h8000_0000);
        chk("R6", "move flags", {28'd0, fout}, 32'hB);
    endtask

    task automatic t_movn_or;
        apply(4'b1111, 1'b1, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'b0110, 1'b1, 1'b0);
        chk("R2", "movn result", res, 32'h0);
        chk("R6", "movn flags", {28'd0, fout}, 32'h4);
        apply(4'b1100, 1'b0, 1'b0, 1'b1, 32'h0F0, 32'h00F, 1'b1, 4'b0000, 1'b1, 1'b0);
        chk("R2", "or result", res, 32'h0FF);
        chk("R6", "or flags", {28'd0, fout}, 32'h2);
    endtask

    task automatic t_rsub;
        logic [31:0] av [5] = '{32'd1, 32'd5, 32'h8000_0000, 32'd7, 32'h0000_0001};
        logic [31:0] bv [5] = '{32'd5, 32'd1, 32'h7FFF_FFFF, 32'd7, 32'h8000_0000};
        for (int i = 0; i < 5; i++) begin
            logic [35:0] e;
            e = model_sub(bv[i], av[i], 1'b1);
            apply(4'b0011, 1'b1, 1'b1, 1'b1, av[i], bv[i], 1'b0, 4'b0000, 1'b1, 1'b0);
            chk("R3", "rsub result", res, e[31:0]);
            chk("R5", "rsub flags", {28'd0, fout}, {28'd0, e[35:32]});
        end
    endtask

    task automatic t_rsubc;
        for (int c = 0; c < 2; c++) begin
            logic [35:0] e;
            e = model_sub(32'd10, 32'd10, c[0]);
            apply(4'b0111, 1'b1, 1'b0, 1'b0, 32'd10, 32'd10, 1'b0,
                  {2'b00, c[0], 1'b0}, 1'b1, 1'b0);
            chk("R4", "rsubc result", res, e[31:0]);
            chk("R5", "rsubc flags", {28'd0, fout}, {28'd0, e[35:32]});
        end
    endtask

    task automatic t_noflags;
        apply(4'b0011, 1'b1, 1'b0, 1'b0, 32'd9, 32'd3, 1'b1, 4'b1010, 1'b0, 1'b0);
        chk("R7", "noflag result", res, 32'hFFFF_FFFA);
        chk("R7", "noflag flags", {28'd0, fout}, 32'hA);
        apply(4'b1101, 1'b1, 1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 4'b0101, 1'b0, 1'b1);
        chk("R7", "noflag move flags", {28'd0, fout}, 32'h5);
        chk("R8", "no restore without set", {31'd0, rst_o}, 32'd0);
    endtask

    task automatic t_restore;
        apply(4'b0011, 1'b1, 1'b0, 1'b0, 32'd2, 32'd1, 1'b0, 4'b0011, 1'b1, 1'b1);
        chk("R8", "restore strobe", {31'd0, rst_o}, 32'd1);
        chk("R8", "restore flags", {28'd0, fout}, 32'h3);
        chk("R8", "restore result", res, 32'hFFFF_FFFF);
    endtask

    task automatic t_foreign;
        apply(4'b1101, 1'b0, 1'b1, 1'b1, 32'd1, 32'h55, 1'b1, 4'b1001, 1'b1, 1'b1);
        chk("R9", "foreign flag", {31'd0, ndp}, 32'd1);
        chk("R9", "foreign result", res, 32'd0);
        chk("R9", "foreign flags", {28'd0, fout}, 32'h9);
        chk("R9", "foreign restore", {31'd0, rst_o}, 32'd0);
        apply(4'b1101, 1'b1, 1'b1, 1'b1, 32'd1, 32'h55, 1'b1, 4'b1001, 1'b1, 1'b0);
        chk("R9", "imm form not foreign", {31'd0, ndp}, 32'd0);
        chk("R9", "imm form move", res, 32'h55);
    endtask

    task automatic t_other;
        apply(4'b0000, 1'b1, 1'b0, 1'b0, 32'hF, 32'hF, 1'b1, 4'b0110, 1'b1, 1'b1);
        chk("R10", "other result", res, 32'd0);
        chk("R10", "other flags", {28'd0, fout}, 32'h6);
        chk("R10", "other restore", {31'd0, rst_o}, 32'd0);
    endtask

    task automatic t_neg64;
        logic [63:0] xs [3] = '{64'h0000_0001_0000_0000, 64'd5, 64'h8000_0000_0000_0000};
        for (int i = 0; i < 3; i++) begin
            logic [63:0] want;
            logic [31:0] lo;
            logic [3:0]  fl;
            want = 64'd0 - xs[i];
            apply(4'b0011, 1'b1, 1'b0, 1'b0, xs[i][31:0], 32'd0, 1'b0, 4'b0000, 1'b1, 1'b0);
            lo = res;
            fl = fout;
            apply(4'b0111, 1'b1, 1'b0, 1'b0, xs[i][63:32], 32'd0, 1'b0, fl, 1'b1, 1'b0);
            chk("R11", "neg64 low", lo, want[31:0]);
            chk("R11", "neg64 high", res, want[63:32]);
        end
    endtask

    initial begin
        opc = '0; imm = 0; b7 = 0; b4 = 0; rn = '0; op2 = '0;
        shc = 0; fin = '0; sf = 0; pc = 0;
        t_idle;
        t_move;
        t_movn_or;
        t_rsub;
        t_rsubc;
        t_noflags;
        t_restore;
        t_foreign;
        t_other;
        t_neg64;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule